// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero Insertion

This block turns one frame of payload bytes into the raw bit-synchronous HDLC line stream of a single channel. The payload arrives as a byte stream with valid/ready handshaking and two sideband marks, one on the first byte and one on the last. The framed line stream leaves as bytes on a second valid/ready interface. Line bits are packed least-significant bit first, so the earliest bit on the wire sits in bit 0 of each output byte.

A frame is built in this order. An opening flag 0x7E is written as a whole byte. The payload bits follow with a zero inserted after every run of five ones. The complemented 16-bit frame check sequence comes next and is stuffed the same way. Last is a closing flag, serialized bit by bit and never stuffed. Because stuffing moves the bit grid, the closing flag may cross a byte boundary. Any partial byte left after it is topped up with ones. Between frames the channel carries all-ones idle bytes.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is held, out_valid is low. After reset the block is idle, its ones-run count is zero, and its first output byte is 0xFF.
- R2: When no frame is in progress, every output byte is the idle value 0xFF.
- R3: A frame begins with an input byte that has in_first high, accepted while idle. The next output byte is 0x7E, written whole and without stuffing.
- R4: Payload bytes are sent least-significant bit first. Output bits fill each byte from bit 0 upward, so bit 0 holds the earliest line bit.
- R5: After five consecutive 1 bits of payload or check sequence, one 0 bit is inserted and the run count restarts. A 0 data bit also restarts it. The run count never exceeds five.
- R6: The check sequence is the reflected CRC-16 with polynomial 0x8408 and seed 0xFFFF, taken over the payload bytes only. It is inverted and sent low byte first, then high byte, each byte least-significant bit first.
- R7: The closing flag 0x7E is sent bit by bit with no zero insertion. It follows the check sequence directly on the bit grid, including any zero inserted after the last check-sequence bit.
- R8: If the closing flag ends inside an output byte, the unused upper bit positions of that byte are set to 1 and the byte is sent. If the flag ends on a byte boundary, no extra byte is sent.
- R9: While idle, an input byte without in_first is accepted and discarded, and the output stays 0xFF.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold steady. No output byte is lost or duplicated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Block accepts the payload byte this cycle |
| in_data | input | 8 | Payload byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| out_valid | output | 1 | Line byte present |
| out_ready | input | 1 | Downstream takes the line byte |
| out_data | output | 8 | Line byte, earliest bit in bit 0 |

## Verification
The hardest cases to reach from the ports are the stuffing corners. One is a run of five ones that ends exactly on the last payload bit, so the zero lands between payload and check sequence. Another is a run of five ones that ends on the final check-sequence bit, so the zero comes just before the closing flag. The check sequence cannot be set directly, so every single-byte frame is sent: each payload value yields a different check sequence, and together they cover both corners and every alignment of the closing flag. Multi-byte frames of all ones, flag-valued bytes and mixed patterns are then sent under pseudo-random back-pressure. Each is compared byte for byte with a line stream the bench builds from the requirements.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
    localparam int unsigned FCS_W     = 16;
    localparam int unsigned FCS_CNT_W = $clog2(FCS_W) + 1;
    localparam int unsigned RUN_LIMIT = 5;
    localparam int unsigned RUN_W     = $clog2(RUN_LIMIT + 1);

    localparam logic [FCS_W-1:0]  FCS_POLY     = 16'h8408;
    localparam logic [FCS_W-1:0]  FCS_SEED     = 16'hFFFF;
    localparam logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E;
    localparam logic [BYTE_W-1:0] IDLE_PATTERN = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_CHECK,
        ST_CLOSE,
        ST_FILL
    } tx_phase_e;

    typedef struct packed {
        logic en;
        logic val;
    } line_bit_t;

    function automatic logic [FCS_W-1:0] fcs_shift(input logic [FCS_W-1:0] r, input logic b);
        logic fb;
        fb = r[0] ^ b;
        return (r >> 1) ^ (fb ? FCS_POLY : '0);
    endfunction

endpackage

// File: rtl/hdlc_fcs_reg.sv
module hdlc_fcs_reg
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_en,
    input  logic             step_en,
    input  logic             step_bit,
    output logic [FCS_W-1:0] fcs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fcs_q <= FCS_SEED;
        end else if (seed_en) begin
            fcs_q <= FCS_SEED;
        end else if (step_en) begin
            fcs_q <= fcs_shift(fcs_q, step_bit);
        end
    end

endmodule

// File: rtl/hdlc_bit_packer.sv
module hdlc_bit_packer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_bit_t         bit_in,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              slot_free,
    output logic              grid_aligned
);

    logic [BYTE_W-1:0]    acc_q;
    logic [BIT_IDX_W-1:0] cnt_q;
    logic [BYTE_W-1:0]    obuf_q;
    logic                 ovalid_q;
    logic [BYTE_W-1:0]    acc_next;
    logic                 byte_full;

    assign acc_next     = {bit_in.val, acc_q[BYTE_W-1:1]};
    assign byte_full    = bit_in.en && (cnt_q == BIT_IDX_W'(BYTE_W - 1));
    assign slot_free    = !ovalid_q || out_ready;
    assign grid_aligned = (cnt_q == '0);
    assign out_valid    = ovalid_q;
    assign out_data     = obuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            obuf_q   <= IDLE_PATTERN;
            ovalid_q <= 1'b0;
        end else begin
            if (bit_in.en) begin
                acc_q <= acc_next;
                cnt_q <= cnt_q + 1'b1;
            end
            if (load_en) begin
                obuf_q   <= load_byte;
                ovalid_q <= 1'b1;
            end else if (byte_full) begin
                obuf_q   <= acc_next;
                ovalid_q <= 1'b1;
            end else if (out_ready) begin
                ovalid_q <= 1'b0;
            end
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/hdlc_tx_sequencer.sv
module hdlc_tx_sequencer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              slot_free,
    input  logic              grid_aligned,
    input  logic [FCS_W-1:0]  fcs_q,
    output line_bit_t         bit_out,
    output logic              load_en,
    output logic [BYTE_W-1:0] load_byte,
    output logic              crc_seed,
    output logic              crc_step,
    output logic              is_idle
);

    tx_phase_e            phase_q, phase_d;
    logic [BYTE_W-1:0]    sh_q;
    logic                 have_q;
    logic                 last_q;
    logic [BIT_IDX_W-1:0] bidx_q;
    logic [RUN_W-1:0]     run_q;
    logic [FCS_CNT_W-1:0] fcnt_q;
    logic [BIT_IDX_W-1:0] gcnt_q;
    logic                 run_full;
    logic                 stuff;
    logic                 take;
    logic                 byte_end;

    assign run_full = (run_q == RUN_W'(RUN_LIMIT));
    assign byte_end = (bidx_q == BIT_IDX_W'(BYTE_W - 1));
    assign is_idle  = (phase_q == ST_IDLE);
    assign take     = in_valid && in_ready && ((phase_q != ST_IDLE) || in_first);

    always_comb begin
        phase_d   = phase_q;
        bit_out   = '{en: 1'b0, val: 1'b0};
        load_en   = 1'b0;
        load_byte = IDLE_PATTERN;
        crc_seed  = 1'b0;
        crc_step  = 1'b0;
        in_ready  = 1'b0;
        stuff     = 1'b0;
        unique case (phase_q)
            ST_IDLE: begin
                in_ready = slot_free;
                if (slot_free) begin
                    load_en = 1'b1;
                    if (in_valid && in_first) begin
                        load_byte = FLAG_PATTERN;
                        crc_seed  = 1'b1;
                        phase_d   = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                in_ready = slot_free && !have_q;
                if (slot_free) begin
                    if (run_full) begin
                        bit_out.en = 1'b1;
                        stuff      = 1'b1;
                    end else if (have_q) begin
                        bit_out.en  = 1'b1;
                        bit_out.val = sh_q[0];
                        crc_step    = 1'b1;
                        if (byte_end && last_q) phase_d = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (slot_free) begin
                    if (run_full) begin
                        bit_out.en = 1'b1;
                        stuff      = 1'b1;
                    end else if (fcnt_q != FCS_CNT_W'(FCS_W)) begin
                        bit_out.en  = 1'b1;
                        bit_out.val = ~fcs_q[fcnt_q[FCS_CNT_W-2:0]];
                    end else begin
                        phase_d = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                if (slot_free) begin
                    bit_out.en  = 1'b1;
                    bit_out.val = FLAG_PATTERN[gcnt_q];
                    if (gcnt_q == BIT_IDX_W'(BYTE_W - 1)) phase_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (slot_free) begin
                    if (!grid_aligned) begin
                        bit_out.en  = 1'b1;
                        bit_out.val = 1'b1;
                    end else begin
                        phase_d = ST_IDLE;
                    end
                end
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            sh_q    <= '0;
            have_q  <= 1'b0;
            last_q  <= 1'b0;
            bidx_q  <= '0;
            run_q   <= '0;
            fcnt_q  <= '0;
            gcnt_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (take) begin
                sh_q   <= in_data;
                have_q <= 1'b1;
                last_q <= in_last;
                bidx_q <= '0;
            end
            if (crc_step) begin
                sh_q   <= sh_q >> 1;
                bidx_q <= bidx_q + 1'b1;
                if (byte_end) have_q <= 1'b0;
            end
            if (phase_q == ST_IDLE) begin
                run_q  <= '0;
                fcnt_q <= '0;
            end else if (bit_out.en && (phase_q == ST_BODY || phase_q == ST_CHECK)) begin
                run_q <= (stuff || !bit_out.val) ? '0 : run_q + 1'b1;
                if (phase_q == ST_CHECK && !stuff) fcnt_q <= fcnt_q + 1'b1;
            end
            if (phase_q == ST_CLOSE && bit_out.en) gcnt_q <= gcnt_q + 1'b1;
        end
    end

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(RUN_LIMIT));

    // R5
    stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_full && slot_free && (phase_q == ST_BODY || phase_q == ST_CHECK))
        |=> (run_q == '0));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data
);

    line_bit_t         line_bit;
    logic              load_en;
    logic [BYTE_W-1:0] load_byte;
    logic              slot_free;
    logic              grid_aligned;
    logic              crc_seed;
    logic              crc_step;
    logic              is_idle;
    logic [FCS_W-1:0]  fcs_q;

    hdlc_tx_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_first     (in_first),
        .in_last      (in_last),
        .in_ready     (in_ready),
        .slot_free    (slot_free),
        .grid_aligned (grid_aligned),
        .fcs_q        (fcs_q),
        .bit_out      (line_bit),
        .load_en      (load_en),
        .load_byte    (load_byte),
        .crc_seed     (crc_seed),
        .crc_step     (crc_step),
        .is_idle      (is_idle)
    );

    hdlc_fcs_reg u_fcs (
        .clk      (clk),
        .rst      (rst),
        .seed_en  (crc_seed),
        .step_en  (crc_step),
        .step_bit (line_bit.val),
        .fcs_q    (fcs_q)
    );

    hdlc_bit_packer u_pack (
        .clk          (clk),
        .rst          (rst),
        .bit_in       (line_bit),
        .load_en      (load_en),
        .load_byte    (load_byte),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .slot_free    (slot_free),
        .grid_aligned (grid_aligned)
    );

    // R3
    open_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (is_idle && in_valid && in_ready && in_first)
        |=> (out_valid && out_data == FLAG_PATTERN));

    // R2
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (is_idle && in_ready && !(in_valid && in_first))
        |=> (out_valid && out_data == IDLE_PATTERN));

endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] pl_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    logic       mbits[$];
    int         mrun;

    logic       bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic       hold_pend = 1'b0;
    logic [7:0] hold_val = 8'h00;

    always #2 clk = ~clk;

    hdlc_tx_framer uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_first  (in_first),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                // R10: held byte must stay presented
                chk(out_valid && out_data == hold_val, "R10", {out_valid, out_data}, {1'b1, hold_val});
            end
            hold_pend = out_valid && !out_ready;
            hold_val  = out_data;
            if (out_valid && out_ready) got_q.push_back(out_data);
        end
    end

    function automatic void push_stuffed(input logic b);
        mbits.push_back(b);
        mrun = b ? mrun + 1 : 0;
        if (mrun == 5) begin
            mbits.push_back(1'b0);
            mrun = 0;
        end
    endfunction

    function automatic logic [15:0] bench_fcs();
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (pl_q[k]) begin
            c = c ^ {8'h00, pl_q[k]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic void make_expected();
        logic [15:0] f;
        logic [7:0]  flag;
        logic [7:0]  b;
        flag = 8'h7E;
        mbits.delete();
        exp_q.delete();
        mrun = 0;
        for (int i = 0; i < 8; i++) mbits.push_back(flag[i]);
        foreach (pl_q[k]) for (int i = 0; i < 8; i++) push_stuffed(pl_q[k][i]);
        f = bench_fcs();
        for (int i = 0; i < 16; i++) push_stuffed(f[i]);
        for (int i = 0; i < 8; i++) mbits.push_back(flag[i]);
        while ((mbits.size() % 8) != 0) mbits.push_back(1'b1);
        for (int k = 0; k < mbits.size() / 8; k++) begin
            for (int i = 0; i < 8; i++) b[i] = mbits[8 * k + i];
            exp_q.push_back(b);
        end
    endfunction

    task automatic push_byte(input logic [7:0] d, input logic f, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        in_last  = l;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(input int wait_cyc, input string tag);
        int s;
        int mism;
        int act;
        int expv;
        bit tail_ok;
        got_q.delete();
        make_expected();
        foreach (pl_q[k]) push_byte(pl_q[k], k == 0, k == pl_q.size() - 1);
        repeat (wait_cyc) @(posedge clk);
        #1;
        s = 0;
        while (s < got_q.size() && got_q[s] == 8'hFF) s++;
        mism = 0;
        act  = 0;
        expv = 0;
        if (got_q.size() < s + exp_q.size()) begin
            mism = 1;
            act  = got_q.size() - s;
            expv = exp_q.size();
        end else begin
            for (int k = 0; k < exp_q.size(); k++) begin
                if (got_q[s + k] !== exp_q[k] && mism == 0) begin
                    act  = got_q[s + k];
                    expv = exp_q[k];
                    mism = 1;
                end
            end
        end
        // R3 R4 R5 R6 R7 R8: exact line image of the frame
        chk(mism == 0, {"R3/R4/R5/R6/R7/R8 ", tag}, act, expv);
        tail_ok = 1'b1;
        for (int k = s + exp_q.size(); k < got_q.size(); k++)
            if (got_q[k] != 8'hFF) tail_ok = 1'b0;
        // R2: idle after frame
        chk(tail_ok, {"R2 idle after ", tag}, tail_ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit all_ff;
        repeat (3) @(negedge clk);
        // R1: no output while in reset
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle byte after reset
        chk(out_valid && out_data == 8'hFF, "R1 post-reset", out_data, 8'hFF);
        @(posedge clk);
        #1;

        // R6: bench check-sequence model on the standard check string
        pl_q.delete();
        for (int i = 0; i < 9; i++) pl_q.push_back(8'h31 + 8'(i));
        chk(bench_fcs() == 16'h906E, "R6 model", bench_fcs(), 16'h906E);

        // R2: pure idle stream
        got_q.delete();
        repeat (50) @(posedge clk);
        #1;
        all_ff = 1'b1;
        foreach (got_q[k]) if (got_q[k] != 8'hFF) all_ff = 1'b0;
        chk(all_ff && got_q.size() >= 40, "R2 idle", got_q.size(), 40);

        // R9: bytes without a start mark are dropped while idle
        got_q.delete();
        push_byte(8'h7E, 1'b0, 1'b0);
        push_byte(8'h00, 1'b0, 1'b1);
        push_byte(8'h55, 1'b0, 1'b0);
        repeat (30) @(posedge clk);
        #1;
        all_ff = 1'b1;
        foreach (got_q[k]) if (got_q[k] != 8'hFF) all_ff = 1'b0;
        chk(all_ff, "R9 discard", all_ff, 1);

        // every single-byte frame, no back-pressure
        for (int v = 0; v < 256; v++) begin
            pl_q.delete();
            pl_q.push_back(8'(v));
            run_frame(90, "single");
        end

        // multi-byte frames under back-pressure (R10)
        bp_en = 1'b1;
        for (int p = 0; p < 5; p++) begin
            for (int len = 1; len <= 8; len++) begin
                pl_q.delete();
                for (int k = 0; k < len; k++) begin
                    case (p)
                        0: pl_q.push_back(8'hFF);
                        1: pl_q.push_back(8'h7E);
                        2: pl_q.push_back(8'(k * 37 + 13));
                        3: pl_q.push_back(8'h00);
                        default: pl_q.push_back((k % 2) ? 8'hF8 : 8'h3F);
                    endcase
                end
                run_frame(150 + 70 * len, "multi");
            end
        end
        bp_en = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule